// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

The block holds a small bank of independent down-counting timers behind one 32-bit register port. Each timer has its own four-word window: a live counter, a reload value and two compare values. A shared control word turns each timer on and lets it raise interrupts. When enabled, a timer steps down by one on every cycle in which the `tick` clock-enable is high. After it has reached zero, the next step loads it from its reload value.

A timer event happens when a step lands the counter on zero or on either compare value. Each event inverts that timer's interrupt line, so the line changes level once per event instead of pulsing. The same event also sets a sticky per-timer bit in a status word. Software clears status bits by writing a mask that is ANDed in. A second control address clears control bits by writing ones, so software can stop a single timer without a read-modify-write.

Three timers fit below the shared registers: windows start at 0x00, 0x10 and 0x20, and the timer index is the address divided by 16.

Top module: `tmr_bank`

## Requirements
- R1: After reset, the control word (0x30), the status word (0x34), every counter, reload and compare register, and every `irq_out` bit read as 0.
- R2: Timer n's window starts at 16*n. Offset +0x0 is the counter, +0x4 the reload value, +0x8 compare A and +0xC compare B. Each is written by `reg_we` and read back on `reg_rdata` in the same cycle that `reg_addr` selects it. Reading +0x0 returns the live count.
- R3: Timer n steps on a cycle when `tick` is 1 and control bit 4n is 1. A step moves a nonzero count down by one and moves a zero count to the reload value. With `tick` low or bit 4n clear, the count holds.
- R4: With control bit 4n+2 set, a step whose new count equals 0, compare A or compare B is an event. An event sets status bit n and inverts `irq_out[n]` at the same clock edge as the step. With bit 4n+2 clear, steps produce no event.
- R5: Reading 0x34 returns status bit n for timer n, with the upper bits 0. Writing 0x34 ANDs the write data into the status word: a 0 clears a bit and a 1 leaves it alone. The write does not change `irq_out`.
- R6: When an event and a status write land on the same cycle, the event's bit ends up set, and the write still clears the other bits it names.
- R7: 0x30 is a read/write control word. A write to 0x3C clears each control bit that is 1 in the data. Reading 0x3C returns 0.
- R8: Every other offset is unmapped and reads 0, and writes to it change nothing. This covers 0x38, unaligned addresses and offsets at or above 0x40.
- R9: When a counter write and a step of the same timer land on the same cycle, the written value is loaded and that step raises no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Count enable shared by all timers |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | NUM_TMR | Per-timer interrupt level, inverted on each event |

## Verification
Reads are combinational, so a value is due on `reg_rdata` in the same cycle the address is presented. A register write becomes readable from the cycle after the edge that takes it. A `tick` cycle updates the count, the status bit and the `irq_out` level together at the one edge that samples it, so all three are due one edge after `tick` is driven. The bench drives every input just after a falling edge and samples 1 ns after the following falling edge. Every result it reads is therefore the settled value after exactly one rising edge. The same-cycle collisions (event against a status clear, counter write against a step) are built by raising both inputs in one cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h30;
  localparam logic [7:0] OFF_STS  = 8'h34;
  localparam logic [7:0] OFF_CCLR = 8'h3C;
  localparam int CTRL_STRIDE = 4;
  localparam int EN_BIT      = 0;
  localparam int IE_BIT      = 2;
  localparam int WIN_BYTES   = 16;

  typedef enum logic [1:0] {
    SEL_CNT = 2'd0,
    SEL_RLD = 2'd1,
    SEL_MA  = 2'd2,
    SEL_MB  = 2'd3
  } win_sel_e;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                en,
  input  logic                ie,
  input  logic                win_we,
  input  tmr_pkg::win_sel_e   sel,
  input  logic [CNT_W-1:0]    wdata,
  output logic [CNT_W-1:0]    rdata,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                evt
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic [CNT_W-1:0] ma_q, ma_d;
  logic [CNT_W-1:0] mb_q, mb_d;
  logic [CNT_W-1:0] cnt_step;
  logic             step;
  logic             wr_cnt;

  assign step   = tick & en;
  assign wr_cnt = win_we && (sel == SEL_CNT);

  always_comb begin
    cnt_step = (cnt_q == '0) ? rld_q : cnt_q - CNT_W'(1);
    cnt_d    = cnt_q;
    if (wr_cnt)    cnt_d = wdata;
    else if (step) cnt_d = cnt_step;
    rld_d = (win_we && sel == SEL_RLD) ? wdata : rld_q;
    ma_d  = (win_we && sel == SEL_MA)  ? wdata : ma_q;
    mb_d  = (win_we && sel == SEL_MB)  ? wdata : mb_q;
    evt   = step && ie && !wr_cnt &&
            ((cnt_step == '0) || (cnt_step == ma_q) || (cnt_step == mb_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      ma_q  <= '0;
      mb_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      ma_q  <= ma_d;
      mb_q  <= mb_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CNT: rdata = cnt_q;
      SEL_RLD: rdata = rld_q;
      SEL_MA:  rdata = ma_q;
      SEL_MB:  rdata = mb_q;
      default: rdata = '0;
    endcase
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_set,
  input  logic        wr_clr,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl_q
);
  logic [31:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_set)      ctrl_d = wdata;
    else if (wr_clr) ctrl_d = ctrl_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int NUM_TMR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TMR-1:0] evt,
  input  logic               clr_we,
  input  logic [NUM_TMR-1:0] keep_mask,
  output logic [NUM_TMR-1:0] sts_q,
  output logic [NUM_TMR-1:0] irq_q
);
  logic [NUM_TMR-1:0] sts_d, irq_d;

  always_comb begin
    sts_d = clr_we ? (sts_q & keep_mask) : sts_q;
    sts_d = sts_d | evt;
    irq_d = irq_q ^ evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      irq_q <= '0;
    end else begin
      sts_q <= sts_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int NUM_TMR = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [NUM_TMR-1:0] irq_out
);
  import tmr_pkg::*;

  localparam int IDX_W = ADDR_W - 4;

  logic                     aligned;
  logic                     hit_ctrl, hit_sts, hit_cclr;
  logic [NUM_TMR-1:0]       win_hit;
  logic [NUM_TMR-1:0]       evt;
  logic [NUM_TMR-1:0]       sts_q;
  logic [31:0]              ctrl_q;
  logic [CNT_W-1:0]         ch_rdata [NUM_TMR];
  logic [NUM_TMR*CNT_W-1:0] cnt_flat;
  win_sel_e                 sel;

  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign hit_ctrl = (reg_addr == ADDR_W'(OFF_CTRL));
  assign hit_sts  = (reg_addr == ADDR_W'(OFF_STS));
  assign hit_cclr = (reg_addr == ADDR_W'(OFF_CCLR));
  assign sel      = win_sel_e'(reg_addr[3:2]);

  tmr_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_set (reg_we && hit_ctrl),
    .wr_clr (reg_we && hit_cclr),
    .wdata  (reg_wdata),
    .ctrl_q (ctrl_q)
  );

  for (genvar n = 0; n < NUM_TMR; n++) begin : g_chan
    assign win_hit[n] = aligned && (reg_addr[ADDR_W-1:4] == IDX_W'(n));

    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .en     (ctrl_q[CTRL_STRIDE*n + EN_BIT]),
      .ie     (ctrl_q[CTRL_STRIDE*n + IE_BIT]),
      .win_we (reg_we && win_hit[n]),
      .sel    (sel),
      .wdata  (reg_wdata[CNT_W-1:0]),
      .rdata  (ch_rdata[n]),
      .cnt_o  (cnt_flat[n*CNT_W +: CNT_W]),
      .evt    (evt[n])
    );
  end

  tmr_status #(.NUM_TMR(NUM_TMR)) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .clr_we    (reg_we && hit_sts),
    .keep_mask (reg_wdata[NUM_TMR-1:0]),
    .sts_q     (sts_q),
    .irq_q     (irq_out)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl) reg_rdata = ctrl_q;
    if (hit_sts)  reg_rdata = 32'(sts_q);
    for (int n = 0; n < NUM_TMR; n++) begin
      if (win_hit[n]) reg_rdata = 32'(ch_rdata[n]);
    end
  end
endmodule

// File: rtl/tmr_bank_checker.sv
module tmr_bank_checker #(
  parameter int NUM_TMR = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic                     reg_we,
  input logic [31:0]              reg_wdata,
  input logic [31:0]              reg_rdata,
  input logic [NUM_TMR-1:0]       irq_out,
  input logic [NUM_TMR-1:0]       sts_q,
  input logic [31:0]              ctrl_q,
  input logic [NUM_TMR*CNT_W-1:0] cnt_flat
);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_CCLR = ADDR_W'(8'h3C);
  localparam logic [ADDR_W-1:0] A_GAP  = ADDR_W'(8'h38);

  AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != $past(irq_out)) |-> (((irq_out ^ $past(irq_out)) & ~sts_q) == '0)); // R4

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_STS) |=> ((~sts_q & $past(sts_q)) == '0)); // R5

  AST_CTRL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CCLR) |=> ((ctrl_q & $past(reg_wdata)) == 32'd0)); // R7

  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_GAP) |-> (reg_rdata == 32'd0)); // R8

  for (genvar n = 0; n < NUM_TMR; n++) begin : g_hold
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(n * 16);
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(tick && ctrl_q[4*n]) && !(reg_we && reg_addr == A_CNT))
        |=> $stable(cnt_flat[n*CNT_W +: CNT_W])); // R3
  end
endmodule

bind tmr_bank tmr_bank_checker #(
  .NUM_TMR (NUM_TMR),
  .CNT_W   (CNT_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .sts_q     (sts_q),
  .ctrl_q    (ctrl_q),
  .cnt_flat  (cnt_flat)
);

// File: tb/tmr_bank_tb_top.sv
module tmr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5ns clk = ~clk;

  tmr_bank dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; reg_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1ns;
    v = reg_rdata;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic test_reset();
    logic [31:0] v;
    do_reset();
    wr(8'h30, 32'h0000_0055); wr(8'h00, 32'h1); wr(8'h14, 32'h77);
    tk(1);
    do_reset();
    rd(8'h30, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h34, v); chk("R1 status", v, 32'h0);
    rd(8'h00, v); chk("R1 count0", v, 32'h0);
    rd(8'h14, v); chk("R1 reload1", v, 32'h0);
    chk("R1 irq", 32'(irq_out), 32'h0);
  endtask

  task automatic test_window();
    logic [31:0] v;
    do_reset();
    wr(8'h14, 32'hA5A5_0001); wr(8'h18, 32'h0000_1234); wr(8'h1C, 32'hFFFF_0000);
    wr(8'h20, 32'h0000_00C3); wr(8'h2C, 32'h0BAD_F00D);
    rd(8'h14, v); chk("R2 t1 reload", v, 32'hA5A5_0001);
    rd(8'h18, v); chk("R2 t1 cmpA", v, 32'h0000_1234);
    rd(8'h1C, v); chk("R2 t1 cmpB", v, 32'hFFFF_0000);
    rd(8'h20, v); chk("R2 t2 count", v, 32'h0000_00C3);
    rd(8'h2C, v); chk("R2 t2 cmpB", v, 32'h0BAD_F00D);
    rd(8'h04, v); chk("R2 t0 reload untouched", v, 32'h0);
  endtask

  task automatic test_count();
    logic [31:0] v;
    do_reset();
    wr(8'h00, 32'd5); wr(8'h30, 32'h1);
    tk(3);
    rd(8'h00, v); chk("R3 three steps", v, 32'd2);
    repeat (3) @(negedge clk);
    rd(8'h00, v); chk("R3 hold without tick", v, 32'd2);
    wr(8'h30, 32'h0); tk(2);
    rd(8'h00, v); chk("R3 hold when disabled", v, 32'd2);
    wr(8'h04, 32'd7); wr(8'h00, 32'd1); wr(8'h30, 32'h1);
    tk(1);
    rd(8'h00, v); chk("R3 reach zero", v, 32'd0);
    tk(1);
    rd(8'h00, v); chk("R3 reload after zero", v, 32'd7);
    rd(8'h34, v); chk("R4 no event with ie clear", v, 32'h0);
  endtask

  task automatic test_event();
    logic [31:0] v;
    do_reset();
    wr(8'h00, 32'd3); wr(8'h04, 32'd9); wr(8'h08, 32'd2); wr(8'h30, 32'h5);
    tk(1);
    rd(8'h34, v); chk("R4 cmpA event status", v, 32'h1);
    chk("R4 cmpA event irq", 32'(irq_out), 32'h1);
    tk(1);
    chk("R4 no event irq holds", 32'(irq_out), 32'h1);
    tk(1);
    chk("R4 zero event toggles irq back", 32'(irq_out), 32'h0);
    rd(8'h34, v); chk("R4 status stays set", v, 32'h1);
    tk(1);
    rd(8'h00, v); chk("R4 reload value", v, 32'd9);
    chk("R4 reload not an event", 32'(irq_out), 32'h0);
    wr(8'h0C, 32'd8); tk(1);
    chk("R4 cmpB event", 32'(irq_out), 32'h1);
    wr(8'h10, 32'd1); wr(8'h30, 32'h15);
    tk(1);
    rd(8'h10, v); chk("R4 t1 reached zero", v, 32'd0);
    rd(8'h34, v); chk("R4 t1 no event without ie", v, 32'h1);
    chk("R4 t1 irq quiet", 32'(irq_out), 32'h1);
  endtask

  task automatic test_status_and();
    logic [31:0] v;
    do_reset();
    wr(8'h00, 32'd1); wr(8'h10, 32'd1); wr(8'h30, 32'h55);
    tk(1);
    rd(8'h34, v); chk("R5 two events", v, 32'h3);
    wr(8'h30, 32'h0);
    wr(8'h34, 32'hFFFF_FFFE);
    rd(8'h34, v); chk("R5 zero bit clears", v, 32'h2);
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, v); chk("R5 ones keep", v, 32'h2);
    chk("R5 irq untouched by clear", 32'(irq_out), 32'h3);
  endtask

  task automatic test_set_wins();
    logic [31:0] v;
    do_reset();
    wr(8'h00, 32'd1); wr(8'h10, 32'd1); wr(8'h30, 32'h50);
    tk(1);
    rd(8'h34, v); chk("R6 setup t1", v, 32'h2);
    wr(8'h30, 32'h05);
    @(negedge clk);
    tick = 1'b1; reg_addr = 8'h34; reg_wdata = 32'h0; reg_we = 1'b1;
    @(negedge clk);
    tick = 1'b0; reg_we = 1'b0;
    rd(8'h34, v); chk("R6 set beats clear", v, 32'h1);
  endtask

  task automatic test_ctrl();
    logic [31:0] v;
    do_reset();
    wr(8'h30, 32'hF0F0_0055);
    rd(8'h30, v); chk("R7 ctrl readback", v, 32'hF0F0_0055);
    wr(8'h3C, 32'h1000_0015);
    rd(8'h30, v); chk("R7 clear by ones", v, 32'hE0F0_0040);
    rd(8'h3C, v); chk("R7 clear port reads zero", v, 32'h0);
  endtask

  task automatic test_unmapped();
    logic [31:0] v;
    do_reset();
    wr(8'h30, 32'h11);
    wr(8'h38, 32'hFFFF_FFFF); wr(8'h40, 32'h1234); wr(8'h31, 32'hFF); wr(8'h05, 32'h77);
    rd(8'h38, v); chk("R8 0x38 reads zero", v, 32'h0);
    rd(8'h40, v); chk("R8 0x40 reads zero", v, 32'h0);
    rd(8'h31, v); chk("R8 unaligned reads zero", v, 32'h0);
    rd(8'h30, v); chk("R8 ctrl unchanged", v, 32'h11);
    rd(8'h04, v); chk("R8 reload unchanged", v, 32'h0);
    rd(8'h34, v); chk("R8 status unchanged", v, 32'h0);
  endtask

  task automatic test_write_vs_step();
    logic [31:0] v;
    do_reset();
    wr(8'h00, 32'd10); wr(8'h08, 32'd4); wr(8'h30, 32'h5);
    @(negedge clk);
    tick = 1'b1; reg_addr = 8'h00; reg_wdata = 32'd4; reg_we = 1'b1;
    @(negedge clk);
    tick = 1'b0; reg_we = 1'b0;
    rd(8'h00, v); chk("R9 write wins", v, 32'd4);
    rd(8'h34, v); chk("R9 no event on written step", v, 32'h0);
    tk(1);
    rd(8'h00, v); chk("R9 counting resumes", v, 32'd3);
  endtask

  initial begin
    test_reset();
    test_window();
    test_count();
    test_event();
    test_status_and();
    test_set_wins();
    test_ctrl();
    test_unmapped();
    test_write_vs_step();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule